// File: doc/BRIEF.md
# MESI Line Coherence Controller

This block keeps the coherence state of one cache line in a write-back cache attached to an atomic snooping bus. The line is always in one of four states: Modified (only copy, newer than memory), Exclusive (only copy, same as memory), Shared (possibly other copies, same as memory) or Invalid. Local hits are served in one cycle. Misses, and writes that need ownership, raise a bus request and then run a three-cycle bus transaction. The transaction is either a plain read or a read-for-ownership.

While watching the bus, the controller votes on a wired-OR shared line for the two cycles after any plain read of a line it holds. The requester samples that line in the second of those cycles and fills Exclusive when nobody voted, or Shared when someone did. A Modified holder always supplies the data. When cache-to-cache transfer is enabled, a clean holder also supplies data, but only if no higher-priority cache on a flush priority chain is already flushing. This gives exactly one supplier for a line held in Shared by several caches. An Exclusive line becomes Modified on a local write with no bus traffic.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset the line is Invalid (line_state encoding: 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified) and bus_req, shared_out and flush_out are low.
- R2: With no snoop in the cycle, a read to a Shared, Exclusive or Modified line, or a write to an Exclusive or Modified line, raises pr_done in that same cycle with bus_req low; a write to Exclusive leaves the line Modified on the next cycle.
- R3: A read to an Invalid line raises bus_req with bus_rdx low (plain read); the cycle bus_gnt is high is the address phase; pr_done rises two cycles later, and the line becomes Shared if shared_in was high in that cycle, otherwise Exclusive.
- R4: A write to a Shared or Invalid line raises bus_req with bus_rdx high (read-for-ownership), completes two cycles after the grant cycle, and leaves the line Modified.
- R5: A snooped plain read (snp_valid high, snp_rdx low) of a held line drives shared_out high in each of the next two cycles; a Modified line raises flush_out in the next cycle and becomes Shared; an Exclusive line becomes Shared.
- R6: A snooped read-for-ownership (snp_rdx high) makes a Shared, Exclusive or Modified line Invalid on the next cycle, and a Modified line raises flush_out in that cycle.
- R7: With cache-to-cache transfer enabled, a Shared or Exclusive line hit by any snoop raises flush_out in the next cycle only when flush_busy_in is low in that cycle; flush_busy_out is always flush_busy_in OR flush_out.
- R8: A local hit presented in a cycle with snp_valid high gets no pr_done in that cycle and is served in a later cycle.
- R9: A snoop of an Invalid line leaves it Invalid and raises neither shared_out nor flush_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pr_rd | input | 1 | Processor read, held until pr_done |
| pr_wr | input | 1 | Processor write, held until pr_done |
| pr_done | output | 1 | Processor access completes this cycle |
| bus_req | output | 1 | Request for the bus |
| bus_rdx | output | 1 | Requested command: 0 plain read, 1 read-for-ownership |
| bus_gnt | input | 1 | Grant; the cycle it is high is the address phase |
| snp_valid | input | 1 | Another cache's address phase for this line |
| snp_rdx | input | 1 | Snooped command: 0 plain read, 1 read-for-ownership |
| shared_out | output | 1 | This cache's vote on the wired-OR shared line |
| shared_in | input | 1 | Resolved wired-OR shared line |
| flush_out | output | 1 | This cache drives the line's data onto the bus |
| flush_busy_in | input | 1 | A higher-priority cache is flushing |
| flush_busy_out | output | 1 | Flush priority chain to lower-priority caches |
| line_state | output | 2 | Current coherence state |

## Verification
The assertions assume an atomic bus. No snoop arrives while this controller's own transaction is in the two cycles after its grant. A grant and a snoop never share a cycle. Snoops of this line are at least three cycles apart, so one vote window ends before the next begins. The processor never raises read and write together and holds a request until pr_done. The stimulus keeps to this by spacing every snoop with idle cycles, granting only while no snoop is present, and releasing each request right after its completion cycle. It still places a snoop in the same cycle as a pending hit, and in cycles where a request is waiting for its grant.

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl #(
  parameter bit C2C_XFER = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pr_rd,
  input  logic       pr_wr,
  output logic       pr_done,
  output logic       bus_req,
  output logic       bus_rdx,
  input  logic       bus_gnt,
  input  logic       snp_valid,
  input  logic       snp_rdx,
  output logic       shared_out,
  input  logic       shared_in,
  output logic       flush_out,
  input  logic       flush_busy_in,
  output logic       flush_busy_out,
  output logic [1:0] line_state
);

  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} st_t;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_W1 = 2'd1, PH_W2 = 2'd2} ph_t;

  st_t  st;
  ph_t  ph;
  logic op_wr;
  logic vote1, vote2;
  logic dirty_fl, clean_fl;

  wire held   = (st != ST_I);
  wire owned  = (st == ST_E) || (st == ST_M);
  wire idle   = (ph == PH_IDLE);
  wire rd_hit = pr_rd & held & ~snp_valid;
  wire wr_hit = pr_wr & owned & ~snp_valid;

  assign bus_req        = idle & ((pr_rd & ~held) | (pr_wr & ~owned));
  assign bus_rdx        = pr_wr;
  assign pr_done        = (idle & (rd_hit | wr_hit)) | (ph == PH_W2);
  assign shared_out     = vote1 | vote2;
  assign flush_out      = dirty_fl | (C2C_XFER & clean_fl & ~flush_busy_in);
  assign flush_busy_out = flush_busy_in | flush_out;
  assign line_state     = st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_I;
      ph       <= PH_IDLE;
      op_wr    <= 1'b0;
      vote1    <= 1'b0;
      vote2    <= 1'b0;
      dirty_fl <= 1'b0;
      clean_fl <= 1'b0;
    end else begin
      vote1    <= snp_valid & ~snp_rdx & held;
      vote2    <= vote1;
      dirty_fl <= snp_valid & (st == ST_M);
      clean_fl <= snp_valid & ((st == ST_S) || (st == ST_E));

      case (ph)
        PH_IDLE: if (bus_req && bus_gnt) begin
          ph    <= PH_W1;
          op_wr <= pr_wr;
        end
        PH_W1:   ph <= PH_W2;
        default: ph <= PH_IDLE;
      endcase

      if (snp_valid) begin
        if (snp_rdx)   st <= ST_I;
        else if (held) st <= ST_S;
      end else if (ph == PH_W2) begin
        st <= op_wr ? ST_M : (shared_in ? ST_S : ST_E);
      end else if (idle && wr_hit) begin
        st <= ST_M;
      end
    end
  end

  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(pr_rd && pr_wr)); // R2
  AST_SILENT_UPGRADE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && pr_wr && st == ST_E && !snp_valid) |=> (st == ST_M)); // R2
  AST_RD_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_W2 && !op_wr) |=> (st == ($past(shared_in) ? ST_S : ST_E))); // R3
  AST_WR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_W2 && op_wr) |=> (st == ST_M)); // R4
  AST_VOTE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_rdx && held) |=> shared_out); // R5
  AST_DIRTY_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && st == ST_M) |=> flush_out); // R5
  AST_RDX_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_rdx) |=> (st == ST_I)); // R6
  AST_SNOOP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && idle) |-> !pr_done); // R8
  AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && st == ST_I) |=> (!flush_out && st == ST_I)); // R9

endmodule

// File: tb/mesi_line_ctrl_tb.sv
`timescale 1ns/1ps
module mesi_line_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pr_rd = 0, pr_wr = 0, bus_gnt = 0, snp_valid = 0, snp_rdx = 0;
  logic shared_in = 0, flush_busy_in = 0;
  logic pr_done, bus_req, bus_rdx, shared_out, flush_out, flush_busy_out;
  logic [1:0] line_state;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit finished = 0;

  int m_st = 0, m_ph = 0, m_op = 0, m_vote = 0, m_fd = 0, m_fc = 0;

  always #2 clk = ~clk;

  mesi_line_ctrl #(.C2C_XFER(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .pr_rd(pr_rd), .pr_wr(pr_wr), .pr_done(pr_done),
    .bus_req(bus_req), .bus_rdx(bus_rdx), .bus_gnt(bus_gnt),
    .snp_valid(snp_valid), .snp_rdx(snp_rdx), .shared_out(shared_out),
    .shared_in(shared_in), .flush_out(flush_out), .flush_busy_in(flush_busy_in),
    .flush_busy_out(flush_busy_out), .line_state(line_state));

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit hr, hw, req, done, fl;
    hr   = pr_rd && m_st != 0 && !snp_valid;
    hw   = pr_wr && m_st >= 2 && !snp_valid;
    req  = m_ph == 0 && ((pr_rd && m_st == 0) || (pr_wr && m_st <= 1));
    done = (m_ph == 0 && (hr || hw)) || m_ph == 2;
    fl   = m_fd != 0 || (m_fc != 0 && !flush_busy_in);
    chk("line_state", line_state, m_st);
    chk("pr_done", pr_done, done);
    chk("bus_req", bus_req, req);
    if (req) chk("bus_rdx", bus_rdx, pr_wr);
    chk("shared_out", shared_out, m_vote > 0);
    chk("flush_out", flush_out, fl);
    chk("flush_busy_out", flush_busy_out, fl || flush_busy_in);
  endtask

  task automatic step();
    bit hw, req;
    int old;
    hw  = pr_wr && m_st >= 2 && !snp_valid;
    req = m_ph == 0 && ((pr_rd && m_st == 0) || (pr_wr && m_st <= 1));
    old = m_st;
    if (m_vote > 0) m_vote--;
    m_fd = snp_valid && old == 3;
    m_fc = snp_valid && (old == 1 || old == 2);
    if (snp_valid && !snp_rdx && old != 0) m_vote = 2;
    if (snp_valid) begin
      if (snp_rdx) m_st = 0; else if (old != 0) m_st = 1;
    end else if (m_ph == 2) m_st = m_op ? 3 : (shared_in ? 1 : 2);
    else if (m_ph == 0 && hw) m_st = 3;
    if (m_ph == 0) begin
      if (req && bus_gnt) begin m_ph = 1; m_op = pr_wr; end
    end else if (m_ph == 1) m_ph = 2;
    else m_ph = 0;
  endtask

  task automatic cyc(input bit rd, wr, gnt, sv, srdx, shin, busy);
    @(negedge clk);
    pr_rd = rd; pr_wr = wr; bus_gnt = gnt; snp_valid = sv; snp_rdx = srdx;
    shared_in = shin; flush_busy_in = busy;
    #1 compare();
    @(posedge clk);
    step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic miss(input bit wr, input bit shin);
    cyc(!wr, wr, 0, 0, 0, 0, 0);
    cyc(!wr, wr, 1, 0, 0, 0, 0);
    cyc(!wr, wr, 0, 0, 0, 0, 0);
    cyc(!wr, wr, 0, 0, 0, shin, 0);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    tag = "R1"; idle(2);
    chk("R1 reset state", line_state, 0);
    tag = "R9"; cyc(0, 0, 0, 1, 0, 0, 0); idle(3);
    cyc(0, 0, 0, 1, 1, 0, 0); idle(3);
    tag = "R3"; miss(0, 0); idle(1);
    chk("R3 fill exclusive", line_state, 2);
    tag = "R2"; cyc(1, 0, 0, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0, 0); idle(1);
    chk("R2 silent upgrade", line_state, 3);
    tag = "R8"; cyc(1, 0, 0, 1, 0, 0, 0); cyc(1, 0, 0, 0, 0, 0, 0); idle(3);
    tag = "R5"; chk("R5 M to S", line_state, 1);
    tag = "R7"; cyc(0, 0, 0, 1, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0, 0); idle(2);
    cyc(0, 0, 0, 1, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0, 1); idle(2);
    cyc(0, 0, 0, 1, 1, 0, 0); cyc(0, 0, 0, 0, 0, 0, 1); idle(2);
    chk("R7 S to I", line_state, 0);
    tag = "R3"; miss(0, 1); idle(1);
    chk("R3 fill shared", line_state, 1);
    tag = "R4"; miss(1, 0); idle(1);
    chk("R4 S write to M", line_state, 3);
    tag = "R6"; cyc(0, 0, 0, 1, 1, 0, 1); idle(3);
    chk("R6 M to I", line_state, 0);
    tag = "R4"; cyc(0, 1, 0, 0, 0, 0, 0); cyc(0, 1, 0, 1, 1, 0, 0); miss(1, 1); idle(1);
    chk("R4 I write to M", line_state, 3);
    tag = "R5"; cyc(0, 0, 0, 1, 0, 0, 1); idle(3);
    tag = "R6"; cyc(0, 0, 0, 1, 1, 0, 0); idle(3);
    tag = "R7"; miss(0, 0); cyc(0, 0, 0, 1, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0, 0); idle(3);
    chk("R7 E to S", line_state, 1);
    tag = "R8"; cyc(1, 0, 0, 1, 1, 0, 0); miss(0, 0); idle(2);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule